// File: doc/BRIEF.md
# Paged Address Translator with Tagged Lookup Buffer

This block turns a logical address into a physical address under single-level paging. The logical address is split into a page number in the upper bits and a byte offset in the lower `OFS_W` bits. A small fully associative lookup buffer holds recent translations. Each slot keeps a page number, a frame number, an address-space tag, two protection bits and a valid flag. When the page number and the current address-space tag both match a valid slot, the frame number is joined with the offset, which passes through unchanged, and the result comes back one cycle after the request is accepted.

When no slot matches, the block reads one page-table word over a simple request/acknowledge memory read port. The word address is the table base plus the page number. A valid word is written into a free slot, or, when every slot is in use, into the least recently used slot. The translation then completes. Before any lookup, the page number is checked against a table-length limit. After lookup or fetch, the access kind is checked against the slot's protection bits, and each failure is reported with its own fault code.

Software can drop every slot in one cycle, or only the slots that carry a chosen address-space tag. One request is in flight at a time.

Top module: `addr_xlate`

## Requirements
- R1: The physical address is `{frame, offset}`: the low `OFS_W` bits of the logical address appear unchanged in the low bits of `rsp_paddr`. For example, with 4-byte pages, address 13 is page 3 offset 1, and if page 3 maps to frame 2 the result is 9.
- R2: A hit needs a valid slot whose page number equals the request's and whose tag equals `cur_asid`. A hit gives `rsp_valid` with `rsp_hit`=1 in the cycle after acceptance, and issues no memory read.
- R3: On a miss, `mem_req` is raised with `mem_addr` = `pt_base` + page number and held steady until `mem_ack`. The response follows in the next cycle with `rsp_hit`=0, and the pair is kept so that a later reference with the same tag hits. The table word is `{valid[PFN_W+2], prot[PFN_W+1:PFN_W], frame[PFN_W-1:0]}`.
- R4: A fetched word goes into the lowest-index empty slot. When all `ENTRIES` slots are valid, it replaces the least recently used slot, where both hits and installs count as use.
- R5: A page number greater than or equal to `pt_len` gives fault code 1 (out of range) in the cycle after acceptance, with no memory read.
- R6: A table word whose valid bit is 0 gives fault code 2 (unmapped page). It is not kept, so a repeat of the request reads memory again.
- R7: Protection code 0 allows read only, 1 allows read and write, 2 allows fetch only, and 3 allows nothing. Access code 0 is read, 1 is write, 2 is fetch. A disallowed access gives fault code 3. Any fault returns `rsp_paddr`=0. Fault code 0 means success.
- R8: `flush_all` clears every slot at the clock edge. A lookup accepted at that same edge still sees the old contents, and a slot installed at that same edge is discarded.
- R9: `flush_asid` clears only the slots whose tag equals `flush_asid_id`.
- R10: `req_ready` is 1 only when no request is in flight, so it is 0 while a memory read is outstanding.
- R11: After reset, all slots are empty, `req_ready`=1, `rsp_valid`=0 and `mem_req`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_vaddr | input | VA_W | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| cur_asid | input | ASID_W | Address-space tag of the running process |
| pt_base | input | MA_W | Page-table base word address |
| pt_len | input | VPN_W+1 | Number of valid page-table words |
| flush_all | input | 1 | Clear every slot |
| flush_asid | input | 1 | Clear the slots with a matching tag |
| flush_asid_id | input | ASID_W | Tag used by `flush_asid` |
| mem_req | output | 1 | Page-table read request |
| mem_addr | output | MA_W | Page-table read word address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | PFN_W+3 | Page-table word |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_paddr | output | PFN_W+OFS_W | Physical address |
| rsp_fault | output | 2 | 0 ok, 1 out of range, 2 unmapped, 3 protection |
| rsp_hit | output | 1 | Result came from the buffer |

## Verification
Two functions can fall in the same cycle: a flush and a buffer access. In the first case, the bench raises `flush_all` together with a request that hits, and expects a hit response followed by a miss on the next identical request. In the second case, the memory model raises `flush_all` together with `mem_ack`. It then expects a correct miss response, but a fresh memory read on the repeat, which shows that the install was discarded rather than kept.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    typedef enum logic [1:0] {PR_RO = 2'd0, PR_RW = 2'd1, PR_XO = 2'd2, PR_NONE = 2'd3} prot_e;
    typedef enum logic [1:0] {AC_READ = 2'd0, AC_WRITE = 2'd1, AC_FETCH = 2'd2, AC_RSVD = 2'd3} acc_e;
    typedef enum logic [1:0] {FT_NONE = 2'd0, FT_BOUNDS = 2'd1, FT_UNMAPPED = 2'd2, FT_PROT = 2'd3} fault_e;
    typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} st_e;
endpackage

// File: rtl/xlt_match.sv
module xlt_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 10,
    parameter int ASID_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ENTRIES-1:0]                slot_v,
    input  logic [ENTRIES-1:0][VPN_W-1:0]     slot_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0]    slot_asid,
    input  logic [VPN_W-1:0]                  key_vpn,
    input  logic [ASID_W-1:0]                 key_asid,
    output logic                              hit,
    output logic [IDX_W-1:0]                  hit_idx
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = slot_v[g] && (slot_vpn[g] == key_vpn) && (slot_asid[g] == key_asid);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match;

    // R2: a (page, tag) pair is never held twice
    a_r2_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match) <= 1);
endmodule

// File: rtl/xlt_lru.sv
module xlt_lru #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] slot_v,
    input  logic               touch,
    input  logic [IDX_W-1:0]   touch_idx,
    output logic [IDX_W-1:0]   victim
);
    logic [ENTRIES-1:0][IDX_W-1:0] age_d, age_q;
    logic [ENTRIES-1:0]            oldest;
    logic                          found;

    always_comb begin
        age_d = age_q;
        if (touch) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age_d[i] = '0;
                else if (age_q[i] < age_q[touch_idx])
                    age_d[i] = age_q[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign oldest[g] = (age_q[g] == IDX_W'(ENTRIES - 1));
    end

    always_comb begin
        victim = '0;
        found  = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && !slot_v[i]) begin
                victim = IDX_W'(i);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (oldest[i]) victim = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
        end else begin
            age_q <= age_d;
        end
    end

    // R4: ages stay a permutation, so exactly one slot is the oldest
    a_r4_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);
endmodule

// File: rtl/xlt_perm.sv
module xlt_perm
    import xlt_pkg::*;
(
    input  prot_e prot,
    input  acc_e  acc,
    output logic  ok
);
    always_comb begin
        unique case (prot)
            PR_RO:   ok = (acc == AC_READ);
            PR_RW:   ok = (acc == AC_READ) || (acc == AC_WRITE);
            PR_XO:   ok = (acc == AC_FETCH);
            default: ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import xlt_pkg::*;
#(
    parameter int VA_W    = 12,
    parameter int OFS_W   = 2,
    parameter int PFN_W   = 8,
    parameter int ASID_W  = 4,
    parameter int MA_W    = 16,
    parameter int ENTRIES = 16,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PA_W   = PFN_W + OFS_W,
    localparam int PTE_W  = PFN_W + 3,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [1:0]        req_acc,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [MA_W-1:0]   pt_base,
    input  logic [VPN_W:0]    pt_len,
    input  logic              flush_all,
    input  logic              flush_asid,
    input  logic [ASID_W-1:0] flush_asid_id,
    output logic              mem_req,
    output logic [MA_W-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [PTE_W-1:0]  mem_rdata,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [1:0]        rsp_fault,
    output logic              rsp_hit
);
    typedef struct packed {
        st_e                            st;
        logic [VPN_W-1:0]               vpn;
        logic [OFS_W-1:0]               ofs;
        logic [1:0]                     acc;
        logic [ASID_W-1:0]              asid;
        logic                           rsp_v;
        logic [PA_W-1:0]                paddr;
        logic [1:0]                     fault;
        logic                           hit;
        logic [ENTRIES-1:0]             ent_v;
        logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
        logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
        logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
        logic [ENTRIES-1:0][1:0]        ent_prot;
    } state_t;

    state_t q, n;

    logic [VPN_W-1:0] key_vpn;
    logic             oob;
    logic             hit;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] victim;
    logic             touch;
    logic [IDX_W-1:0] touch_idx;
    logic             pte_v;
    logic [1:0]       pte_prot;
    logic [PFN_W-1:0] pte_pfn;
    prot_e            chk_prot;
    acc_e             chk_acc;
    logic             perm_ok;

    assign key_vpn  = req_vaddr[VA_W-1:OFS_W];
    assign oob      = {1'b0, key_vpn} >= pt_len;
    assign pte_v    = mem_rdata[PFN_W+2];
    assign pte_prot = mem_rdata[PFN_W+1:PFN_W];
    assign pte_pfn  = mem_rdata[PFN_W-1:0];

    xlt_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .slot_v(q.ent_v), .slot_vpn(q.ent_vpn), .slot_asid(q.ent_asid),
        .key_vpn(key_vpn), .key_asid(cur_asid),
        .hit(hit), .hit_idx(hit_idx)
    );

    xlt_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst_n(rst_n), .slot_v(q.ent_v),
        .touch(touch), .touch_idx(touch_idx), .victim(victim)
    );

    assign chk_prot = prot_e'((q.st == ST_IDLE) ? q.ent_prot[hit_idx] : pte_prot);
    assign chk_acc  = acc_e'((q.st == ST_IDLE) ? req_acc : q.acc);

    xlt_perm u_perm (.prot(chk_prot), .acc(chk_acc), .ok(perm_ok));

    always_comb begin
        n         = q;
        n.rsp_v   = 1'b0;
        touch     = 1'b0;
        touch_idx = hit_idx;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    n.vpn  = key_vpn;
                    n.ofs  = req_vaddr[OFS_W-1:0];
                    n.acc  = req_acc;
                    n.asid = cur_asid;
                    if (oob) begin
                        n.rsp_v = 1'b1;
                        n.hit   = 1'b0;
                        n.fault = FT_BOUNDS;
                        n.paddr = '0;
                    end else if (hit) begin
                        n.rsp_v = 1'b1;
                        n.hit   = 1'b1;
                        touch   = 1'b1;
                        n.fault = perm_ok ? FT_NONE : FT_PROT;
                        n.paddr = perm_ok ? {q.ent_pfn[hit_idx], req_vaddr[OFS_W-1:0]} : '0;
                    end else begin
                        n.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    n.st    = ST_IDLE;
                    n.rsp_v = 1'b1;
                    n.hit   = 1'b0;
                    if (!pte_v) begin
                        n.fault = FT_UNMAPPED;
                        n.paddr = '0;
                    end else begin
                        n.ent_v[victim]    = 1'b1;
                        n.ent_vpn[victim]  = q.vpn;
                        n.ent_asid[victim] = q.asid;
                        n.ent_pfn[victim]  = pte_pfn;
                        n.ent_prot[victim] = pte_prot;
                        touch              = 1'b1;
                        touch_idx          = victim;
                        n.fault = perm_ok ? FT_NONE : FT_PROT;
                        n.paddr = perm_ok ? {pte_pfn, q.ofs} : '0;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase
        if (flush_all) n.ent_v = '0;
        if (flush_asid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (n.ent_asid[i] == flush_asid_id) n.ent_v[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign req_ready = (q.st == ST_IDLE);
    assign mem_req   = (q.st == ST_FETCH);
    assign mem_addr  = pt_base + MA_W'(q.vpn);
    assign rsp_valid = q.rsp_v;
    assign rsp_paddr = q.paddr;
    assign rsp_fault = q.fault;
    assign rsp_hit   = q.hit;

    a_r5_bounds_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && oob) |=> (rsp_valid && rsp_fault == FT_BOUNDS && !mem_req));
    a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && !oob && hit) |=> (rsp_valid && rsp_hit && !mem_req));
    a_r3_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (q.ent_v == '0));
    a_r7_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FT_NONE) |-> (rsp_paddr == '0));
    a_r6_unmapped_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !pte_v) |=> (rsp_valid && rsp_fault == FT_UNMAPPED && !rsp_hit));
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FT_NONE) |-> (rsp_paddr[OFS_W-1:0] == q.ofs));
endmodule

// File: tb/addr_xlate_test.sv
module addr_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [11:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic [3:0]  cur_asid = 4'd1;
    logic [15:0] pt_base = 16'd16;
    logic [10:0] pt_len = 11'd1024;
    logic        flush_all;
    logic        flush_task = 1'b0;
    logic        flush_resp = 1'b0;
    logic        flush_on_ack = 1'b0;
    logic        flush_asid = 1'b0;
    logic [3:0]  flush_asid_id = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [10:0] mem_rdata = '0;
    logic        rsp_valid;
    logic [9:0]  rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        rsp_hit;

    logic [10:0] mem_model [0:2047];
    int          reads = 0;
    int          wait_cnt = 0;
    logic [15:0] last_addr = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    assign flush_all = flush_task | flush_resp;

    always #4 clk = ~clk;

    addr_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_acc(req_acc), .cur_asid(cur_asid),
        .pt_base(pt_base), .pt_len(pt_len), .flush_all(flush_all),
        .flush_asid(flush_asid), .flush_asid_id(flush_asid_id),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_hit(rsp_hit)
    );

    function automatic logic [10:0] mk_pte(input logic v, input logic [1:0] p, input logic [7:0] f);
        return {v, p, f};
    endfunction

    function automatic logic [9:0] exp_pa(input logic [11:0] va);
        return {mem_model[16 + int'(va[11:2])][7:0], va[1:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model: acknowledges the second cycle of each read
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                flush_resp = 1'b0;
                wait_cnt = 0;
            end else if (mem_req) begin
                wait_cnt++;
                if (wait_cnt == 2) begin
                    mem_ack = 1'b1;
                    mem_rdata = mem_model[mem_addr[10:0]];
                    last_addr = mem_addr;
                    reads++;
                    flush_resp = flush_on_ack;
                end
            end
        end
    end

    task automatic xlate(input logic [11:0] va, input logic [1:0] acc, input logic fl,
                         output logic [9:0] pa, output logic [1:0] ft, output logic ht, output int nr);
        int r0 = reads;
        bit got = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_acc = acc; flush_task = fl;
        @(negedge clk);
        req_valid = 1'b0; flush_task = 1'b0;
        for (int k = 0; k < 50; k++) begin
            if (rsp_valid) begin got = 1; break; end
            @(negedge clk);
        end
        pa = rsp_paddr; ft = rsp_fault; ht = rsp_hit; nr = reads - r0;
        if (!got) begin n_chk++; n_bad++; $display("FAIL no response for %0d", va); end
    endtask

    task automatic expect_x(input string tag, input logic [11:0] va, input logic [1:0] acc,
                            input logic fl, input logic [9:0] epa, input logic [1:0] eft,
                            input logic eht, input int erd);
        logic [9:0] pa; logic [1:0] ft; logic ht; int nr;
        xlate(va, acc, fl, pa, ft, ht, nr);
        chk({tag, " paddr"}, 32'(pa), 32'(epa));
        chk({tag, " fault"}, 32'(ft), 32'(eft));
        chk({tag, " hit"}, 32'(ht), 32'(eht));
        chk({tag, " reads"}, 32'(nr), 32'(erd));
    endtask

    task automatic pulse_flush();
        @(negedge clk); flush_task = 1'b1;
        @(negedge clk); flush_task = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 ready", 32'(req_ready), 1);
        chk("R11 rsp_valid", 32'(rsp_valid), 0);
        chk("R11 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_example();
        mem_model[19] = mk_pte(1'b1, 2'd1, 8'd2);
        expect_x("R1 R3 miss 13", 12'd13, 2'd0, 1'b0, 10'd9, 2'd0, 1'b0, 1);
        chk("R3 read addr", 32'(last_addr), 19);
        expect_x("R2 R1 hit 13", 12'd13, 2'd0, 1'b0, 10'd9, 2'd0, 1'b1, 0);
    endtask

    task automatic t_asid();
        cur_asid = 4'd2;
        expect_x("R2 other tag", 12'd13, 2'd0, 1'b0, 10'd9, 2'd0, 1'b0, 1);
        cur_asid = 4'd1;
        expect_x("R2 tag back", 12'd13, 2'd0, 1'b0, 10'd9, 2'd0, 1'b1, 0);
    endtask

    task automatic t_bounds();
        pt_len = 11'd32;
        expect_x("R5 page 32", 12'd128, 2'd0, 1'b0, 10'd0, 2'd1, 1'b0, 0);
        expect_x("R5 page 31", 12'd126, 2'd0, 1'b0, exp_pa(12'd126), 2'd0, 1'b0, 1);
        pt_len = 11'd1024;
    endtask

    task automatic t_unmapped();
        mem_model[16 + 60] = mk_pte(1'b0, 2'd1, 8'd5);
        expect_x("R6 first", 12'd240, 2'd0, 1'b0, 10'd0, 2'd2, 1'b0, 1);
        expect_x("R6 repeat", 12'd240, 2'd0, 1'b0, 10'd0, 2'd2, 1'b0, 1);
    endtask

    task automatic t_prot();
        mem_model[16 + 70] = mk_pte(1'b1, 2'd0, 8'd9);
        mem_model[16 + 71] = mk_pte(1'b1, 2'd2, 8'd10);
        mem_model[16 + 72] = mk_pte(1'b1, 2'd1, 8'd11);
        mem_model[16 + 73] = mk_pte(1'b1, 2'd3, 8'd12);
        expect_x("R7 ro write", 12'd281, 2'd1, 1'b0, 10'd0, 2'd3, 1'b0, 1);
        expect_x("R7 ro read", 12'd281, 2'd0, 1'b0, {8'd9, 2'd1}, 2'd0, 1'b1, 0);
        expect_x("R7 xo fetch", 12'd286, 2'd2, 1'b0, {8'd10, 2'd2}, 2'd0, 1'b0, 1);
        expect_x("R7 xo read", 12'd286, 2'd0, 1'b0, 10'd0, 2'd3, 1'b1, 0);
        expect_x("R7 rw fetch", 12'd291, 2'd2, 1'b0, 10'd0, 2'd3, 1'b0, 1);
        expect_x("R7 rw write", 12'd291, 2'd1, 1'b0, {8'd11, 2'd3}, 2'd0, 1'b1, 0);
        expect_x("R7 none read", 12'd292, 2'd0, 1'b0, 10'd0, 2'd3, 1'b0, 1);
    endtask

    task automatic t_busy();
        logic [9:0] pa; logic [1:0] ft; logic ht; int nr;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 12'd320; req_acc = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 mem_req during fetch", 32'(mem_req), 1);
        chk("R10 ready during fetch", 32'(req_ready), 0);
        for (int k = 0; k < 20 && !rsp_valid; k++) @(negedge clk);
        chk("R10 ready after", 32'(req_ready), 1);
        xlate(12'd320, 2'd0, 1'b0, pa, ft, ht, nr);
        chk("R10 later hit", 32'(ht), 1);
    endtask

    task automatic t_flush_hit();
        expect_x("R8 hit with flush", 12'd13, 2'd0, 1'b1, 10'd9, 2'd0, 1'b1, 0);
        expect_x("R8 after flush", 12'd13, 2'd0, 1'b0, 10'd9, 2'd0, 1'b0, 1);
    endtask

    task automatic t_flush_install();
        flush_on_ack = 1'b1;
        expect_x("R8 install with flush", 12'd360, 2'd0, 1'b0, exp_pa(12'd360), 2'd0, 1'b0, 1);
        flush_on_ack = 1'b0;
        expect_x("R8 install discarded", 12'd360, 2'd0, 1'b0, exp_pa(12'd360), 2'd0, 1'b0, 1);
        expect_x("R8 old entry gone", 12'd13, 2'd0, 1'b0, 10'd9, 2'd0, 1'b0, 1);
    endtask

    task automatic t_asid_flush();
        cur_asid = 4'd1;
        expect_x("R9 fill tag1", 12'd20, 2'd0, 1'b0, exp_pa(12'd20), 2'd0, 1'b0, 1);
        cur_asid = 4'd2;
        expect_x("R9 fill tag2", 12'd20, 2'd0, 1'b0, exp_pa(12'd20), 2'd0, 1'b0, 1);
        @(negedge clk); flush_asid = 1'b1; flush_asid_id = 4'd1;
        @(negedge clk); flush_asid = 1'b0;
        expect_x("R9 tag2 kept", 12'd20, 2'd0, 1'b0, exp_pa(12'd20), 2'd0, 1'b1, 0);
        cur_asid = 4'd1;
        expect_x("R9 tag1 dropped", 12'd20, 2'd0, 1'b0, exp_pa(12'd20), 2'd0, 1'b0, 1);
    endtask

    task automatic t_lru();
        pulse_flush();
        for (int p = 40; p < 56; p++)
            expect_x("R4 fill", 12'(p * 4), 2'd0, 1'b0, exp_pa(12'(p * 4)), 2'd0, 1'b0, 1);
        expect_x("R4 first kept", 12'd160, 2'd0, 1'b0, exp_pa(12'd160), 2'd0, 1'b1, 0);
        expect_x("R4 last kept", 12'd220, 2'd0, 1'b0, exp_pa(12'd220), 2'd0, 1'b1, 0);
        expect_x("R4 new page", 12'd224, 2'd0, 1'b0, exp_pa(12'd224), 2'd0, 1'b0, 1);
        expect_x("R4 40 survives", 12'd160, 2'd0, 1'b0, exp_pa(12'd160), 2'd0, 1'b1, 0);
        expect_x("R4 41 evicted", 12'd164, 2'd0, 1'b0, exp_pa(12'd164), 2'd0, 1'b0, 1);
        expect_x("R4 43 survives", 12'd172, 2'd0, 1'b0, exp_pa(12'd172), 2'd0, 1'b1, 0);
        expect_x("R4 42 evicted", 12'd168, 2'd0, 1'b0, exp_pa(12'd168), 2'd0, 1'b0, 1);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++)
            mem_model[i] = mk_pte(1'b1, 2'd1, 8'((i * 7 + 3) & 255));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_asid();
        t_bounds();
        t_unmapped();
        t_prot();
        t_busy();
        t_flush_hit();
        t_flush_install();
        t_asid_flush();
        t_lru();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule